// File: doc/BRIEF.md
# Configurable GPIO Port Controller

A register-mapped general-purpose I/O block that manages several 8-bit ports. Each port has a latch and a per-bit direction register, and software reaches both over a simple byte-wide read/write bus. Each pin is presented to the pad ring as separate output-data, output-enable, pull-up-enable and input signals, so the block contains no tristate logic. Inputs are brought in through a two-flop synchronizer before any read can see them.

A port function control register sets three things. It turns the pull-ups on one port's upper nibble and on the non-maskable interrupt pin on or off. It exports an input-threshold select bit. It also holds a 3-bit address/port code that decides which upper address pins are handed back to port use while an external bus mode is active. The chip's operating mode input can force pull-ups off. In the external bus modes it also gives the bus-owned address pins to the external bus controller. For each such pin the block drives no output enable and no pull-up, reads it as zero, and marks it in an ownership mask.

Register map: port p data latch at offset 2p, port p direction at 2p+1, function control at 2·NUM_PORTS. Operating mode codes: 00 single-chip, 01 memory expansion, 10 microprocessor, 11 flash programming.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A direction bit of 1 makes its pin an output (`pin_oe_o` bit = 1, `pin_out_o` bit = latch bit). A direction bit of 0 makes it an input (`pin_oe_o` bit = 0). Port p occupies bits [8p+7:8p] of every pin vector.
- R2: A read of a data register returns the latch bit, not the pin level, for every output-mode pin.
- R3: A write to the data register of an input-mode pin only updates the latch, and its output enable stays 0. A read returns the synchronized pin level. A later switch of the pin to output drives the value written earlier.
- R4: A pull-up is asserted only on port 2 bits 7:4, only while that pin is an input, and only while function control bit 4 is 0.
- R5: `nmi_pu_o` is 1 when function control bit 7 is 0 and 0 when it is 1, outside flash mode.
- R6: Reset clears all latches, all direction bits and the function control register. Function control bits 6:5 always read 0, whatever is written to them.
- R7: In flash-programming mode (11) every pull-up output, including `nmi_pu_o`, is 0.
- R8: In microprocessor mode (10) the pull-up on port 2 bit 4 is 0. The other port-2 upper pull-ups follow R4.
- R9: In modes 01 and 10, port 0 pins are bus-owned unless freed by code bits 2:0. Code 001 frees bits 7:6, 010 frees 7:4, 011 frees 7:2, and 100, 110 and 111 free all of them. A bus-owned pin has `bus_own_o`=1, output enable 0, pull-up 0, and reads 0. In modes 00 and 11 no pin is bus-owned.
- R10: In modes 01 and 10, port 1 is entirely bus-owned except that code 110 frees bits 7:4 and code 111 frees all eight.
- R11: Reserved code 101 gives the same ownership as code 000: ports 0 and 1 fully bus-owned.
- R12: A pin change driven between edges is first visible in read data sampled at the third rising edge after it.
- R13: Read data is registered: it updates at the edge where `bus_rd_i` is sampled high and holds otherwise. Unmapped offsets read 0. Function control bit 3 drives `in_level_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (00 single-chip, 01 expansion, 10 microprocessor, 11 flash) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| pin_in_i | input | 32 | Pad input levels |
| pin_out_o | output | 32 | Pad output data |
| pin_oe_o | output | 32 | Pad output enables |
| pin_pu_o | output | 32 | Pad pull-up enables |
| nmi_pu_o | output | 1 | Pull-up enable for the non-maskable interrupt pin |
| in_level_sel_o | output | 1 | Input threshold select for port 0 |
| bus_own_o | output | 32 | Pins currently owned by the external bus |

## Verification
The assertions check on every cycle that no pin has an output enable without its direction bit, and that no pull-up sits on an output pin or a bus-owned pin. They also check that flash mode leaves every pull-up off and that microprocessor mode keeps the chip-select pull-up off. Further per-cycle checks: the reserved control bits stay zero, single-chip and flash modes own no pins, and read data holds between reads. The bench scenarios cover what needs a history of register writes: latch-versus-pin read-back, latched writes to input pins that appear once the direction turns, the three-edge synchronizer latency, and the full table of address/port codes including the reserved one.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int PW = 8;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_MPU    = 2'b10,
    MODE_FLASH  = 2'b11
  } op_mode_e;

  // External bus is driving address pins in these modes
  function automatic logic ext_bus_active(input logic [1:0] mode);
    return (mode == MODE_EXPAND) || (mode == MODE_MPU);
  endfunction

  // Port-use mask of the port carrying the top address byte
  function automatic logic [PW-1:0] hi_port_free(input logic [2:0] code);
    logic [PW-1:0] m;
    case (code)
      3'b001:                 m = 8'hC0;
      3'b010:                 m = 8'hF0;
      3'b011:                 m = 8'hFC;
      3'b100, 3'b110, 3'b111: m = 8'hFF;
      default:                m = 8'h00; // 000 and reserved 101
    endcase
    return m;
  endfunction

  // Port-use mask of the port carrying the middle address byte
  function automatic logic [PW-1:0] mid_port_free(input logic [2:0] code);
    logic [PW-1:0] m;
    case (code)
      3'b110:  m = 8'hF0;
      3'b111:  m = 8'hFF;
      default: m = 8'h00;
    endcase
    return m;
  endfunction

  // Pull-up permission for the chip-select port
  function automatic logic [PW-1:0] cs_pull_allow(input logic disable_bit,
                                                  input logic [1:0] mode,
                                                  input int cs_bit);
    logic [PW-1:0] m;
    m = disable_bit ? 8'h00 : 8'hF0;
    if (mode == MODE_FLASH) m = 8'h00;
    if (mode == MODE_MPU)   m[cs_bit] = 1'b0;
    return m;
  endfunction

  // Reserved control bits are forced to zero on write
  function automatic logic [PW-1:0] fcr_clean(input logic [PW-1:0] wd);
    return wd & 8'h9F;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
  import gpio_ctrl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data_i,
  input  logic          wr_dir_i,
  input  logic [PW-1:0] wdata_i,
  input  logic [PW-1:0] own_i,
  input  logic [PW-1:0] pu_allow_i,
  input  logic [PW-1:0] pin_in_i,
  output logic [PW-1:0] pin_out_o,
  output logic [PW-1:0] pin_oe_o,
  output logic [PW-1:0] pin_pu_o,
  output logic [PW-1:0] rd_value_o,
  output logic [PW-1:0] dir_o
);
  logic [PW-1:0] latch_q;
  logic [PW-1:0] dir_q;
  logic [PW-1:0] pin_sync;
  logic [PW-1:0] port_use;

  gpio_in_sync #(.W(PW)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_in_i),
    .q_o  (pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_data_i) latch_q <= wdata_i;
      if (wr_dir_i)  dir_q   <= wdata_i;
    end
  end

  assign port_use   = ~own_i;
  assign pin_out_o  = latch_q;
  assign pin_oe_o   = dir_q & port_use;
  assign pin_pu_o   = ~dir_q & pu_allow_i & port_use;
  assign rd_value_o = port_use & ((dir_q & latch_q) | (~dir_q & pin_sync));
  assign dir_o      = dir_q;

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o & ~dir_o) == '0); // R1
  AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu_o & dir_o) == '0); // R4
  AST_OWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe_o | pin_pu_o | rd_value_o) & own_i) == '0); // R9
  AST_DIR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> ($past(dir_o) == '0)); // R6
endmodule

// File: rtl/gpio_bus_owner.sv
module gpio_bus_owner
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int HI_PORT   = 0,
  parameter int MID_PORT  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_i,
  input  logic [2:0]              code_i,
  output logic [NUM_PORTS*PW-1:0] own_o
);
  logic ext_on;
  assign ext_on = ext_bus_active(mode_i);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_own
    if (p == HI_PORT) begin : g_hi
      assign own_o[p*PW +: PW] = ext_on ? ~hi_port_free(code_i) : '0;
    end else if (p == MID_PORT) begin : g_mid
      assign own_o[p*PW +: PW] = ext_on ? ~mid_port_free(code_i) : '0;
    end else begin : g_plain
      assign own_o[p*PW +: PW] = '0;
    end
  end

  AST_SINGLE_NO_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_on |-> (own_o == '0)); // R9
  AST_RSVD_AS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_on && code_i == 3'b101) |-> (own_o[HI_PORT*PW +: PW] == 8'hFF
                                      && own_o[MID_PORT*PW +: PW] == 8'hFF)); // R11
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int HI_PORT   = 0,
  parameter int MID_PORT  = 1,
  parameter int PULL_PORT = 2,
  parameter int CS_BIT    = 4,
  localparam int NPIN     = NUM_PORTS * PW,
  localparam int BUS_AW   = $clog2(2 * NUM_PORTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [PW-1:0]     bus_wdata_i,
  output logic [PW-1:0]     bus_rdata_o,
  input  logic [NPIN-1:0]   pin_in_i,
  output logic [NPIN-1:0]   pin_out_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic [NPIN-1:0]   pin_pu_o,
  output logic              nmi_pu_o,
  output logic              in_level_sel_o,
  output logic [NPIN-1:0]   bus_own_o
);
  localparam logic [BUS_AW-1:0] FCR_ADDR = BUS_AW'(2 * NUM_PORTS);
  localparam int FCR_PU_OFF  = 4;
  localparam int FCR_NMI_OFF = 7;
  localparam int FCR_LVL     = 3;

  logic [PW-1:0]   fcr_q;
  logic [PW-1:0]   cs_allow;
  logic [NPIN-1:0] port_rd;
  logic [NPIN-1:0] port_dir;
  logic [PW-1:0]   rd_mux;
  logic            fcr_wr;

  assign fcr_wr = bus_wr_i && (bus_addr_i == FCR_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fcr_q <= '0;
    else if (fcr_wr) fcr_q <= fcr_clean(bus_wdata_i);
  end

  assign in_level_sel_o = fcr_q[FCR_LVL];
  assign nmi_pu_o = !fcr_q[FCR_NMI_OFF] && (mode_i != MODE_FLASH);
  assign cs_allow = cs_pull_allow(fcr_q[FCR_PU_OFF], mode_i, CS_BIT);

  gpio_bus_owner #(
    .NUM_PORTS(NUM_PORTS),
    .HI_PORT  (HI_PORT),
    .MID_PORT (MID_PORT)
  ) owner_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mode_i(mode_i),
    .code_i(fcr_q[2:0]),
    .own_o (bus_own_o)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic          wr_data;
    logic          wr_dir;
    logic [PW-1:0] allow;
    assign wr_data = bus_wr_i && (bus_addr_i == BUS_AW'(2 * p));
    assign wr_dir  = bus_wr_i && (bus_addr_i == BUS_AW'(2 * p + 1));
    assign allow   = (p == PULL_PORT) ? cs_allow : '0;

    gpio_port_slice slice_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data_i (wr_data),
      .wr_dir_i  (wr_dir),
      .wdata_i   (bus_wdata_i),
      .own_i     (bus_own_o[p*PW +: PW]),
      .pu_allow_i(allow),
      .pin_in_i  (pin_in_i[p*PW +: PW]),
      .pin_out_o (pin_out_o[p*PW +: PW]),
      .pin_oe_o  (pin_oe_o[p*PW +: PW]),
      .pin_pu_o  (pin_pu_o[p*PW +: PW]),
      .rd_value_o(port_rd[p*PW +: PW]),
      .dir_o     (port_dir[p*PW +: PW])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr_i == BUS_AW'(2 * p))     rd_mux = port_rd[p*PW +: PW];
      if (bus_addr_i == BUS_AW'(2 * p + 1)) rd_mux = port_dir[p*PW +: PW];
    end
    if (bus_addr_i == FCR_ADDR) rd_mux = fcr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

  AST_FCR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[6:5] == 2'b00); // R6
  AST_FLASH_PULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FLASH) |-> (pin_pu_o == '0 && !nmi_pu_o)); // R7
  AST_MPU_CS_PULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_MPU) |-> !pin_pu_o[PULL_PORT*PW + CS_BIT]); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd_i) |-> $stable(bus_rdata_o)); // R13
  AST_PU_ONLY_CS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu_o & ~(NPIN'(8'hF0) << (PULL_PORT*PW))) == '0); // R4
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_pu, bus_own;
  logic        nmi_pu, lvl_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .pin_pu_o(pin_pu), .nmi_pu_o(nmi_pu), .in_level_sel_o(lvl_sel),
    .bus_own_o(bus_own)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R6 oe after reset", pin_oe, 32'h0);
    check("R4 pull-ups after reset", pin_pu, 32'h00F0_0000);
    check("R5 nmi pull-up after reset", {31'b0, nmi_pu}, 32'h1);
    check("R9 no ownership in single-chip", bus_own, 32'h0);
    reg_rd(4'd8, v); check("R6 fcr reset", {24'b0, v}, 32'h0);
    reg_rd(4'd7, v); check("R6 dir3 reset", {24'b0, v}, 32'h0);
  endtask

  task automatic t_output_readback();
    logic [7:0] v;
    pin_in[31:24] = 8'h5A;
    reg_wr(4'd6, 8'hA5);
    reg_wr(4'd7, 8'h0F);
    settle(3);
    check("R1 oe follows dir", {24'b0, pin_oe[31:24]}, 32'h0F);
    check("R1 out follows latch", {24'b0, pin_out[31:24]}, 32'hA5);
    reg_rd(4'd6, v);
    check("R2 mixed read latch/pin", {24'b0, v}, 32'h55);
  endtask

  task automatic t_input_write();
    logic [7:0] v;
    reg_wr(4'd7, 8'h00);
    reg_wr(4'd6, 8'h3C);
    check("R3 input write keeps oe off", {24'b0, pin_oe[31:24]}, 32'h0);
    reg_rd(4'd6, v);
    check("R3 input read returns pin", {24'b0, v}, 32'h5A);
    reg_wr(4'd7, 8'hFF);
    check("R3 latched value driven", {24'b0, pin_out[31:24]}, 32'h3C);
    reg_rd(4'd6, v);
    check("R3 output read returns latch", {24'b0, v}, 32'h3C);
    reg_wr(4'd7, 8'h00);
  endtask

  task automatic t_latency();
    logic [7:0] seen [3];
    pin_in[31:24] = 8'h00;
    settle(4);
    @(negedge clk); pin_in[31:24] = 8'hFF; rd = 1'b1; addr = 4'd6;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); seen[i] = rdata;
    end
    rd = 1'b0;
    check("R12 edge1 old", {24'b0, seen[0]}, 32'h00);
    check("R12 edge2 old", {24'b0, seen[1]}, 32'h00);
    check("R12 edge3 new", {24'b0, seen[2]}, 32'hFF);
  endtask

  task automatic t_pullups();
    reg_wr(4'd5, 8'h30);
    check("R4 pull-up only on inputs", pin_pu, 32'h00C0_0000);
    reg_wr(4'd8, 8'h10);
    check("R4 group pull-up disabled", pin_pu, 32'h0);
    check("R5 nmi stays on", {31'b0, nmi_pu}, 32'h1);
    reg_wr(4'd8, 8'h80);
    check("R5 nmi pull-up off", {31'b0, nmi_pu}, 32'h0);
    check("R4 group back on", pin_pu, 32'h00C0_0000);
    reg_wr(4'd5, 8'h00);
  endtask

  task automatic t_fcr_bits();
    logic [7:0] v;
    reg_wr(4'd8, 8'hFF);
    reg_rd(4'd8, v);
    check("R6 reserved bits read zero", {24'b0, v}, 32'h9F);
    check("R13 level select out", {31'b0, lvl_sel}, 32'h1);
    reg_rd(4'd9, v);  check("R13 unmapped 9", {24'b0, v}, 32'h0);
    reg_rd(4'd15, v); check("R13 unmapped 15", {24'b0, v}, 32'h0);
    reg_wr(4'd8, 8'h00);
  endtask

  task automatic t_modes();
    mode = 2'b11; settle(1);
    check("R7 flash pull-ups", pin_pu, 32'h0);
    check("R7 flash nmi", {31'b0, nmi_pu}, 32'h0);
    check("R9 flash owns nothing", bus_own, 32'h0);
    mode = 2'b10; settle(1);
    check("R8 chip-select pull-up off", pin_pu, 32'h00E0_0000);
    check("R8 nmi unaffected", {31'b0, nmi_pu}, 32'h1);
    mode = 2'b00; settle(1);
  endtask

  task automatic t_ownership();
    logic [7:0] v, f0, f1;
    int lines [8] = '{24, 22, 20, 18, 16, 24, 12, 8};
    int c0, c1;
    reg_wr(4'd0, 8'hFF); reg_wr(4'd1, 8'hFF);
    reg_wr(4'd2, 8'hFF); reg_wr(4'd3, 8'hFF);
    mode = 2'b01;
    for (int code = 0; code < 8; code++) begin
      c0 = (24 - lines[code]) > 8 ? 8 : 24 - lines[code];
      c1 = (16 - lines[code]) > 0 ? 16 - lines[code] : 0;
      f0 = 8'(16'hFF00 >> c0);
      f1 = 8'(16'hFF00 >> c1);
      reg_wr(4'd8, 8'(code));
      check(code == 5 ? "R11 reserved code ownership" : "R9 R10 ownership mask",
            bus_own[15:0], {~f1, ~f0});
      check("R9 R10 oe only on freed pins", pin_oe[15:0], {f1, f0});
      reg_rd(4'd0, v); check("R9 owned bits read zero", {24'b0, v}, {24'b0, f0});
      reg_rd(4'd2, v); check("R10 port1 read", {24'b0, v}, {24'b0, f1});
    end
    mode = 2'b00; settle(1);
    check("R9 single-chip releases pins", bus_own, 32'h0);
    check("R1 all outputs back", pin_oe[15:0], 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_output_readback();
    t_input_write();
    t_latency();
    t_pullups();
    t_fcr_bits();
    t_modes();
    t_ownership();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule